// File: doc/BRIEF.md
# DMA Channel Transfer Controller

A single-channel DMA engine that copies data from a source address to a destination address one unit at a time. Each unit is a read from the source followed by a write to the destination over a valid/ready memory master port. Software programs the source, destination, unit count and control fields through a small register port. It then lets the channel run either by itself (auto-request) or paced by an external request strobe.

A unit may start only while five conditions all hold: the channel enable is set, the master enable is set, and the end, NMI and address-error flags are all clear. A request that arrives while any condition fails is held, and it is served once the channel is enabled again. After each unit the count drops by one and each address steps by the unit size, stays fixed, or steps back by the unit size. When the count reaches zero the end flag is set, and an interrupt is raised if it is enabled. A misaligned address or an invalid size code sets the address-error flag and forces its interrupt, and no bus access is made for that unit.

The bus behaviour is selectable. In burst mode the channel holds the bus from unit to unit until the count runs out. In cycle-steal mode it releases the bus after every unit.

Top module: `dma_chan_top`

## Requirements
- R1: A unit's bus access starts only if, in the cycle before, channel enable (control bit 0) and master enable (status bit 0) were 1 and the end flag (status bit 1), NMI flag (status bit 2) and address-error flag (status bit 3) were 0.
- R2: Each unit reads the source address, then writes the data read to the destination address. The size field (control bits 6:4) selects the unit size: 0=1, 1=2, 2=4, 3=8, 4=32 bytes. Mode fields (source bits 9:8, destination bits 11:10) step the address after each unit: 1 adds the unit size, 2 subtracts it, and 0 or 3 leaves it unchanged.
- R3: The count register (index 2) decrements by one for every completed unit.
- R4: The end flag is set when the unit that takes the count from 1 to 0 completes. irq_end_o is high while the end flag and the interrupt enable (control bit 3) are both 1.
- R5: An nmi_i pulse sets the NMI flag. The transfer then stops at the next unit boundary with the count left nonzero, and it resumes once the flag is cleared.
- R6: If the source or destination address is not a multiple of the unit size, or the size code is 5 to 7, the address-error flag is set and no bus access is made. irq_ae_o follows the flag whatever the interrupt enable is.
- R7: The end, NMI and address-error flags are sticky. A status write clears each flag written with 0 and keeps each flag written with 1.
- R8: Clearing channel enable or master enable halts the transfer at the next unit boundary. Setting it again resumes from the remaining count.
- R9: With auto-request (control bit 1) at 0, a dreq_i strobe is held as one pending request, including while the channel is disabled. In cycle-steal mode each held request moves exactly one unit.
- R10: With auto-request at 1, units run with no dreq_i strobe while the channel is enabled and the count is nonzero.
- R11: With burst (control bit 2) at 1, bus_own_o stays high from the first unit to the last. With burst at 0, bus_own_o drops for at least one cycle after each unit.
- R12: While mem_req_o is high and mem_ready_i is low, mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o stay unchanged.
- R13: After reset all registers read 0, mem_req_o is low and both interrupts are low. Register indices are: 0 source, 1 destination, 2 count, 3 control, 4 status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read data for reg_addr_i |
| dreq_i | input | 1 | External transfer request strobe |
| nmi_i | input | 1 | NMI event, sets the NMI flag |
| mem_req_o | output | 1 | Memory access valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Access byte address |
| mem_size_o | output | 3 | Unit size code of the access |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ready_i | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| bus_own_o | output | 1 | Channel holds the bus |
| irq_end_o | output | 1 | Transfer-end interrupt |
| irq_ae_o | output | 1 | Address-error interrupt |

## Verification
The assertions take for granted that software does not rewrite the address or count registers while a unit is on the bus. Their properties are therefore gated off in any cycle that carries a register write. They also take for granted that the memory side completes every access in finite time. The bench writes address and count only while the channel is idle. Its only mid-transfer writes touch the control and status registers. Its memory model answers every request within a few cycles, following a pseudo-random stall pattern.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [2:0] IDX_SRC  = 3'd0;
  localparam logic [2:0] IDX_DST  = 3'd1;
  localparam logic [2:0] IDX_CNT  = 3'd2;
  localparam logic [2:0] IDX_CTRL = 3'd3;
  localparam logic [2:0] IDX_STAT = 3'd4;

  typedef enum logic [1:0] {STEP_HOLD = 2'd0, STEP_INC = 2'd1, STEP_DEC = 2'd2, STEP_HOLD3 = 2'd3} step_e;

  typedef struct packed {
    logic [1:0] dmode;
    logic [1:0] smode;
    logic       rsv;
    logic [2:0] size;
    logic       ie;
    logic       burst;
    logic       autoreq;
    logic       ch_en;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} seq_e;

  // 0 marks a reserved size code
  function automatic logic [5:0] unit_bytes(input logic [2:0] code);
    case (code)
      3'd0: unit_bytes = 6'd1;
      3'd1: unit_bytes = 6'd2;
      3'd2: unit_bytes = 6'd4;
      3'd3: unit_bytes = 6'd8;
      3'd4: unit_bytes = 6'd32;
      default: unit_bytes = 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              unit_done_i,
  input  logic [ADDR_W-1:0] nsrc_i,
  input  logic [ADDR_W-1:0] ndst_i,
  input  logic              ae_set_i,
  input  logic              nmi_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output ctrl_t             ctrl_o,
  output logic              mst_en_o,
  output logic              te_o,
  output logic              nmif_o,
  output logic              ae_o
);
  logic w_src, w_dst, w_cnt, w_ctrl, w_stat;
  assign w_src  = reg_we_i && reg_addr_i == IDX_SRC;
  assign w_dst  = reg_we_i && reg_addr_i == IDX_DST;
  assign w_cnt  = reg_we_i && reg_addr_i == IDX_CNT;
  assign w_ctrl = reg_we_i && reg_addr_i == IDX_CTRL;
  assign w_stat = reg_we_i && reg_addr_i == IDX_STAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o    <= '0;
      dst_o    <= '0;
      cnt_o    <= '0;
      ctrl_o   <= '0;
      mst_en_o <= 1'b0;
      te_o     <= 1'b0;
      nmif_o   <= 1'b0;
      ae_o     <= 1'b0;
    end else begin
      if (w_src) src_o <= reg_wdata_i[ADDR_W-1:0];
      else if (unit_done_i) src_o <= nsrc_i;
      if (w_dst) dst_o <= reg_wdata_i[ADDR_W-1:0];
      else if (unit_done_i) dst_o <= ndst_i;
      if (w_cnt) cnt_o <= reg_wdata_i[CNT_W-1:0];
      else if (unit_done_i) cnt_o <= cnt_o - 1'b1;
      if (w_ctrl) ctrl_o <= ctrl_t'(reg_wdata_i[11:0]);
      if (w_stat) mst_en_o <= reg_wdata_i[0];
      // hardware set wins over a clearing write
      if (unit_done_i && cnt_o == CNT_W'(1)) te_o <= 1'b1;
      else if (w_stat) te_o <= te_o & reg_wdata_i[1];
      if (nmi_i) nmif_o <= 1'b1;
      else if (w_stat) nmif_o <= nmif_o & reg_wdata_i[2];
      if (ae_set_i) ae_o <= 1'b1;
      else if (w_stat) ae_o <= ae_o & reg_wdata_i[3];
    end
  end

  always_comb begin
    case (reg_addr_i)
      IDX_SRC:  reg_rdata_o = REG_W'(src_o);
      IDX_DST:  reg_rdata_o = REG_W'(dst_o);
      IDX_CNT:  reg_rdata_o = REG_W'(cnt_o);
      IDX_CTRL: reg_rdata_o = REG_W'(ctrl_o);
      IDX_STAT: reg_rdata_o = REG_W'({ae_o, nmif_o, te_o, mst_en_o});
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_agen.sv
module dma_chan_agen
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [2:0]        size_i,
  input  logic [1:0]        smode_i,
  input  logic [1:0]        dmode_i,
  output logic [ADDR_W-1:0] nsrc_o,
  output logic [ADDR_W-1:0] ndst_o,
  output logic              align_err_o
);
  logic [5:0]        bytes;
  logic [4:0]        mask;
  logic [ADDR_W-1:0] step;

  assign bytes = unit_bytes(size_i);
  assign mask  = bytes[4:0] - 5'd1;
  assign step  = ADDR_W'(bytes);
  assign align_err_o = (bytes == 6'd0) || ((src_i[4:0] & mask) != 5'd0)
                       || ((dst_i[4:0] & mask) != 5'd0);

  always_comb begin
    case (step_e'(smode_i))
      STEP_INC: nsrc_o = src_i + step;
      STEP_DEC: nsrc_o = src_i - step;
      default:  nsrc_o = src_i;
    endcase
    case (step_e'(dmode_i))
      STEP_INC: ndst_o = dst_i + step;
      STEP_DEC: ndst_o = dst_i - step;
      default:  ndst_o = dst_i;
    endcase
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic              mst_en_i,
  input  logic              te_i,
  input  logic              nmif_i,
  input  logic              ae_i,
  input  logic              cnt_nz_i,
  input  logic              cnt_last_i,
  input  logic              align_err_i,
  input  logic              dreq_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [2:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              bus_own_o,
  output logic              unit_done_o,
  output logic              ae_set_o
);
  seq_e              state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic              pend_q, en_all, want, start;

  assign en_all = ctrl_i.ch_en & mst_en_i & ~te_i & ~nmif_i & ~ae_i;
  assign want   = en_all & cnt_nz_i & (ctrl_i.autoreq | pend_q);

  always_comb begin
    state_d     = state_q;
    start       = 1'b0;
    ae_set_o    = 1'b0;
    unit_done_o = 1'b0;
    case (state_q)
      ST_IDLE: if (want) begin
        if (align_err_i) ae_set_o = 1'b1;
        else begin
          start   = 1'b1;
          state_d = ST_RD;
        end
      end
      ST_RD: if (mem_ready_i) state_d = ST_WR;
      ST_WR: if (mem_ready_i) begin
        unit_done_o = 1'b1;
        state_d = (ctrl_i.burst && en_all && !cnt_last_i) ? ST_RD : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RD && mem_ready_i) data_q <= mem_rdata_i;
      // burst keeps one request armed until the count is exhausted
      if (dreq_i && !ctrl_i.autoreq) pend_q <= 1'b1;
      else if (ae_set_o || (start && !ctrl_i.burst) || (unit_done_o && cnt_last_i))
        pend_q <= 1'b0;
    end
  end

  assign mem_req_o   = state_q != ST_IDLE;
  assign mem_we_o    = state_q == ST_WR;
  assign mem_addr_o  = (state_q == ST_WR) ? dst_i : src_i;
  assign mem_size_o  = ctrl_i.size;
  assign mem_wdata_o = data_q;
  assign bus_own_o   = state_q != ST_IDLE;
endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              dreq_i,
  input  logic              nmi_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [2:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              bus_own_o,
  output logic              irq_end_o,
  output logic              irq_ae_o
);
  logic [ADDR_W-1:0] src_q, dst_q, nsrc, ndst;
  logic [CNT_W-1:0]  cnt_q;
  ctrl_t             ctrl_q;
  logic              mst_en_q, te_q, nmif_q, ae_q;
  logic              unit_done, ae_set, align_err;

  dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .unit_done_i(unit_done), .nsrc_i(nsrc), .ndst_i(ndst), .ae_set_i(ae_set),
    .nmi_i, .src_o(src_q), .dst_o(dst_q), .cnt_o(cnt_q), .ctrl_o(ctrl_q),
    .mst_en_o(mst_en_q), .te_o(te_q), .nmif_o(nmif_q), .ae_o(ae_q)
  );

  dma_chan_agen #(.ADDR_W(ADDR_W)) u_agen (
    .src_i(src_q), .dst_i(dst_q), .size_i(ctrl_q.size), .smode_i(ctrl_q.smode),
    .dmode_i(ctrl_q.dmode), .nsrc_o(nsrc), .ndst_o(ndst), .align_err_o(align_err)
  );

  dma_chan_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .ctrl_i(ctrl_q), .mst_en_i(mst_en_q), .te_i(te_q),
    .nmif_i(nmif_q), .ae_i(ae_q), .cnt_nz_i(cnt_q != '0),
    .cnt_last_i(cnt_q == CNT_W'(1)), .align_err_i(align_err), .dreq_i,
    .src_i(src_q), .dst_i(dst_q), .mem_ready_i, .mem_rdata_i, .mem_req_o,
    .mem_we_o, .mem_addr_o, .mem_size_o, .mem_wdata_o, .bus_own_o,
    .unit_done_o(unit_done), .ae_set_o(ae_set)
  );

  assign irq_end_o = te_q & ctrl_q.ie;
  assign irq_ae_o  = ae_q;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              bus_own_o,
  input logic              irq_ae_o,
  input logic              ch_en_i,
  input logic              burst_i,
  input logic              mst_en_i,
  input logic              te_i,
  input logic              nmif_i,
  input logic              ae_i,
  input logic [CNT_W-1:0]  cnt_i
);
  logic wr_hs, gate_ok;
  assign wr_hs   = mem_req_o && mem_we_o && mem_ready_i;
  assign gate_ok = ch_en_i && mst_en_i && !te_i && !nmif_i && !ae_i;

  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(gate_ok)); // R1
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hs && !reg_we_i) |=> ($past(cnt_i) == cnt_i + 1'b1)); // R3
  AST_END_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hs && !reg_we_i && cnt_i == CNT_W'(1)) |=> te_i); // R4
  AST_AE_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_ae_o) |-> !mem_req_o); // R6
  AST_CS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hs && !burst_i) |=> !bus_own_o); // R11
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i && !reg_we_i) |=>
      (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o) && $stable(mem_wdata_o))); // R12
endmodule

bind dma_chan_top dma_chan_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .mem_req_o(mem_req_o),
  .mem_we_o(mem_we_o), .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .bus_own_o(bus_own_o), .irq_ae_o(irq_ae_o),
  .ch_en_i(ctrl_q.ch_en), .burst_i(ctrl_q.burst), .mst_en_i(mst_en_q),
  .te_i(te_q), .nmif_i(nmif_q), .ae_i(ae_q), .cnt_i(cnt_q)
);

// File: tb/tb_dma_chan_top.sv
module tb_dma_chan_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 64, CW = 16, RW = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we = 1'b0, dreq = 1'b0, nmi = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [RW-1:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ready = 1'b0, bus_own, irq_end, irq_ae;
  logic [AW-1:0] mem_addr;
  logic [2:0] mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;

  int errors = 0, checks = 0;
  int log_n = 0, falls = 0;
  logic [AW-1:0] log_addr [0:255];
  logic          log_we   [0:255];
  logic [DW-1:0] log_data [0:255];
  logic [7:0] lfsr = 8'h5B;
  logic prev_own = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_top #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .REG_W(RW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .dreq_i(dreq), .nmi_i(nmi),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata), .bus_own_o(bus_own), .irq_end_o(irq_end),
    .irq_ae_o(irq_ae)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a ^ 32'hC3C3_0F0F, a};
  endfunction

  function automatic logic [RW-1:0] ctl(input int ch, input int au, input int bu,
      input int ie, input int sz, input int sm, input int dm);
    return RW'((dm << 10) | (sm << 8) | (sz << 4) | (ie << 3) | (bu << 2) | (au << 1) | ch);
  endfunction

  // memory model: decides acceptance for the coming edge and logs it
  always @(negedge clk) begin
    logic rdy;
    rdy = 1'b0;
    if (mem_req) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rdy = lfsr[0] | lfsr[1];
    end
    mem_ready = rdy;
    mem_rdata = pat(mem_addr);
    if (rdy && log_n < 256) begin
      log_addr[log_n] = mem_addr;
      log_we[log_n]   = mem_we;
      log_data[log_n] = mem_wdata;
      log_n = log_n + 1;
    end
    if (prev_own && !bus_own) falls = falls + 1;
    prev_own = bus_own;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [RW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [RW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_dreq();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
  endtask

  task automatic chk_unit(input string tag, input int idx, input logic [AW-1:0] s,
      input logic [AW-1:0] d);
    chk({tag, " rd we"}, 64'(log_we[idx]), 64'd0);
    chk({tag, " rd addr"}, 64'(log_addr[idx]), 64'(s));
    chk({tag, " wr we"}, 64'(log_we[idx+1]), 64'd1);
    chk({tag, " wr addr"}, 64'(log_addr[idx+1]), 64'(d));
    chk({tag, " wr data"}, log_data[idx+1], pat(s));
  endtask

  task automatic setup(input logic [AW-1:0] s, input logic [AW-1:0] d, input int n);
    wr(3'd3, '0);
    wr(3'd4, 32'h1);
    wr(3'd0, s);
    wr(3'd1, d);
    wr(3'd2, RW'(n));
  endtask

  task automatic t_reset();
    logic [RW-1:0] v;
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), v);
      chk($sformatf("R13 reset reg %0d", i), 64'(v), 64'd0);
    end
    chk("R13 reset mem_req", 64'(mem_req), 64'd0);
    chk("R13 reset irqs", 64'({irq_end, irq_ae}), 64'd0);
  endtask

  task automatic t_auto_cs();
    logic [RW-1:0] v;
    int b, f;
    setup(32'h100, 32'h800, 3);
    b = log_n; f = falls;
    wr(3'd3, ctl(1, 1, 0, 1, 2, 1, 1));
    cyc(200);
    chk("R10 auto access count", 64'(log_n - b), 64'd6);
    for (int k = 0; k < 3; k++)
      chk_unit("R2 inc 4B", b + 2*k, 32'h100 + 32'(4*k), 32'h800 + 32'(4*k));
    chk("R11 cycle-steal releases", 64'(falls - f), 64'd3);
    rd(3'd2, v); chk("R3 count to zero", 64'(v), 64'd0);
    rd(3'd0, v); chk("R2 src final", 64'(v), 64'h10C);
    rd(3'd4, v); chk("R4 end flag", 64'(v), 64'h3);
    chk("R4 irq_end with ie", 64'(irq_end), 64'd1);
    wr(3'd4, 32'h1);
    chk("R7 end flag cleared by 0", 64'(irq_end), 64'd0);
  endtask

  task automatic t_burst();
    logic [RW-1:0] v;
    int b, f;
    setup(32'h2000, 32'h3018, 4);
    b = log_n; f = falls;
    wr(3'd3, ctl(1, 1, 1, 0, 3, 0, 2));
    cyc(200);
    chk("R11 burst access count", 64'(log_n - b), 64'd8);
    for (int k = 0; k < 4; k++)
      chk_unit("R2 fixed/dec 8B", b + 2*k, 32'h2000, 32'h3018 - 32'(8*k));
    chk("R11 burst single release", 64'(falls - f), 64'd1);
    rd(3'd1, v); chk("R2 dst final", 64'(v), 64'h2FF8);
    rd(3'd4, v); chk("R4 end flag burst", 64'(v), 64'h3);
    chk("R4 irq_end masked", 64'(irq_end), 64'd0);
    wr(3'd4, 32'h1);
  endtask

  task automatic t_ext_req();
    logic [RW-1:0] v;
    int b;
    setup(32'h41, 32'h51, 5);
    b = log_n;
    wr(3'd3, ctl(1, 0, 0, 0, 0, 1, 1));
    cyc(50);
    chk("R9 no strobe no access", 64'(log_n - b), 64'd0);
    pulse_dreq(); cyc(50);
    chk("R9 one unit per strobe", 64'(log_n - b), 64'd2);
    chk_unit("R9 unit 1B", b, 32'h41, 32'h51);
    pulse_dreq(); cyc(50);
    chk("R9 second strobe", 64'(log_n - b), 64'd4);
    rd(3'd2, v); chk("R3 count after two", 64'(v), 64'd3);
    // wait state: strobe while master disabled
    wr(3'd4, 32'h0);
    pulse_dreq(); cyc(50);
    chk("R1 held while disabled", 64'(log_n - b), 64'd4);
    wr(3'd4, 32'h1); cyc(50);
    chk("R9 held request served", 64'(log_n - b), 64'd6);
    chk_unit("R9 resumed unit", b + 4, 32'h43, 32'h53);
    rd(3'd2, v); chk("R3 count after resume", 64'(v), 64'd2);
    wr(3'd3, '0);
  endtask

  task automatic t_addr_err();
    logic [RW-1:0] v;
    int b;
    setup(32'h102, 32'h200, 2);
    b = log_n;
    wr(3'd3, ctl(1, 1, 0, 0, 2, 1, 1));
    cyc(20);
    chk("R6 misaligned no access", 64'(log_n - b), 64'd0);
    rd(3'd4, v); chk("R6 ae flag", 64'(v), 64'h9);
    chk("R6 irq_ae without ie", 64'(irq_ae), 64'd1);
    rd(3'd2, v); chk("R6 count untouched", 64'(v), 64'd2);
    wr(3'd4, 32'h9); rd(3'd4, v);
    chk("R7 write 1 keeps flag", 64'(v), 64'h9);
    wr(3'd3, '0); wr(3'd4, 32'h1);
    chk("R7 write 0 clears ae", 64'(irq_ae), 64'd0);
    wr(3'd0, 32'h100);
    wr(3'd3, ctl(1, 1, 0, 0, 5, 1, 1));
    cyc(20);
    chk("R6 reserved size no access", 64'(log_n - b), 64'd0);
    chk("R6 reserved size irq", 64'(irq_ae), 64'd1);
    wr(3'd3, '0); wr(3'd4, 32'h1);
  endtask

  task automatic t_nmi();
    logic [RW-1:0] v;
    int b;
    setup(32'h400, 32'h600, 8);
    b = log_n;
    wr(3'd3, ctl(1, 1, 1, 0, 2, 1, 1));
    cyc(3);
    nmi = 1'b1; @(negedge clk); nmi = 1'b0;
    cyc(60);
    rd(3'd4, v); chk("R5 nmi flag", 64'(v), 64'h5);
    rd(3'd2, v);
    chk("R5 halted with count left", 64'(v != 0), 64'd1);
    chk("R5 accesses match count", 64'(log_n - b), 64'(2 * (8 - int'(v))));
    wr(3'd4, 32'h1); cyc(150);
    rd(3'd2, v); chk("R5 resumed to zero", 64'(v), 64'd0);
    chk("R5 total accesses", 64'(log_n - b), 64'd16);
    chk_unit("R5 last unit", b + 14, 32'h41C, 32'h61C);
    wr(3'd3, '0); wr(3'd4, 32'h1);
  endtask

  task automatic t_disable_mid();
    logic [RW-1:0] v;
    int b;
    setup(32'h700, 32'h900, 6);
    b = log_n;
    wr(3'd3, ctl(1, 1, 1, 0, 1, 1, 1));
    cyc(3);
    wr(3'd3, ctl(0, 1, 1, 0, 1, 1, 1));
    cyc(60);
    rd(3'd2, v);
    chk("R8 halted count left", 64'(v != 0), 64'd1);
    chk("R8 accesses match count", 64'(log_n - b), 64'(2 * (6 - int'(v))));
    rd(3'd4, v); chk("R8 no end flag", 64'(v), 64'h1);
    wr(3'd3, ctl(1, 1, 1, 0, 1, 1, 1)); cyc(150);
    rd(3'd2, v); chk("R8 resumed to zero", 64'(v), 64'd0);
    chk("R8 total accesses", 64'(log_n - b), 64'd12);
    chk_unit("R8 last unit", b + 10, 32'h70A, 32'h90A);
    // end flag blocks a new count until cleared
    b = log_n;
    wr(3'd0, 32'hA00); wr(3'd2, 32'd2); cyc(30);
    chk("R1 end flag blocks", 64'(log_n - b), 64'd0);
    wr(3'd4, 32'h1); cyc(80);
    chk("R1 runs after clear", 64'(log_n - b), 64'd4);
    rd(3'd4, v); chk("R4 end flag again", 64'(v), 64'h3);
    wr(3'd3, '0); wr(3'd4, 32'h1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog R1..R13 actual=timeout expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    t_reset();
    rst_ni = 1'b1;
    cyc(2);
    t_auto_cs();
    t_burst();
    t_ext_req();
    t_addr_err();
    t_nmi();
    t_disable_mid();
    finish_run();
  end
endmodule